// File: doc/BRIEF.md
# Remote DMA Write-Setup Sequencer

This block sits on the host side of a network controller and prepares its remote DMA channel for a write. A single start pulse begins the sequence. The block first issues a remote read command that moves no useful data and serves only as a dummy. It then polls the controller's 16-bit current remote address, one byte at a time, until the value moves. Between polls it waits a programmable number of cycles. Once the address has moved, it loads the remote byte count and the remote start address and issues the remote write command.

In the pre-adjusted mode, the count and address are loaded before the dummy read, as the count plus one and the address minus one. The dummy read advances both registers to the values the write needs, so the block skips the second set of loads. If the address never moves within a programmable number of polls, the block stops, pulses done without issuing the write, and raises an error flag.

The controller side is a plain register port. A write strobe carries an address and a data byte. A read strobe returns its data on the next cycle.

Top module: `rdma_wsetup_seq`

## Requirements
- R1: After reset, busy, done and timeout_err are 0, and neither reg_rd nor reg_wr is asserted while the block is idle.
- R2: In normal mode (pre_adjust=0), the first port action after start is a write of 0x0A (dummy remote read command) to register 0.
- R3: In pre-adjusted mode, start is followed by four writes before the dummy command: (count+1) low byte to 0xA, high byte to 0xB, (address−1) low byte to 0x8, high byte to 0x9. Both adjustments wrap modulo 2^16.
- R4: Each poll is a read strobe at register 0x5 followed on the next cycle by a read strobe at register 0x6. reg_rdata is sampled the cycle after each strobe, and the polled value is {byte from 0x6, byte from 0x5}. A change in either byte alone counts as a change.
- R5: The first poll after the dummy command only records a baseline. If a later poll matches the previous value, the block polls again, and the high-byte read strobe and the next low-byte read strobe are exactly poll_delay+3 cycles apart.
- R6: In normal mode, a poll that differs from the previous value is followed by writes of the count low byte to 0xA, count high byte to 0xB, address low byte to 0x8 and address high byte to 0x9. A write of 0x12 (remote write command) to register 0 follows.
- R7: In pre-adjusted mode, a differing poll is followed directly by the 0x12 command write, with no count or address writes.
- R8: done is a one-cycle pulse in the cycle after the command write. busy is high from the cycle after start through the done cycle and low in the cycle after.
- R9: When poll_limit consecutive compared polls have all matched, the block issues no further port action, pulses done with timeout_err=1, and holds timeout_err until the next accepted start, which clears it.
- R10: If the address moves on the compared poll that would reach poll_limit, the change takes precedence: the setup completes and timeout_err stays 0.
- R11: A start pulse while busy is ignored; the running sequence and its values are unchanged.
- R12: reg_rd and reg_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a setup sequence (ignored while busy) |
| pre_adjust | input | 1 | Select pre-adjusted mode, latched at start |
| xfer_count | input | 16 | Transmit byte count, latched at start |
| xfer_addr | input | 16 | Remote start address, latched at start |
| poll_delay | input | DLY_W | Idle cycles added between polls, latched at start |
| poll_limit | input | LIM_W | Matching compared polls allowed before timeout, latched at start |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 4 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout_err | output | 1 | Address never moved within poll_limit polls |

## Verification
The compare stage can see two things on the same poll: the address has just moved, and the matched-poll count has reached its limit. The bench provokes this by programming the change to land on the final allowed poll, here poll_limit=3 with the change on the third compared poll. It judges the result by the full write setup plus the command write appearing in the scoreboard, with timeout_err low at done. A neighbouring run moves the change one poll later and must time out instead.

// File: rtl/rdma_ws_pkg.sv
package rdma_ws_pkg;

    localparam int BYTE_W   = 8;
    localparam int CADDR_W  = 16;
    localparam int RSEL_W   = 4;
    localparam int SETUP_N  = 4;
    localparam int IDX_W    = $clog2(SETUP_N);

    // controller register selects
    localparam logic [RSEL_W-1:0] SEL_CMD    = 4'h0;
    localparam logic [RSEL_W-1:0] SEL_CUR_LO = 4'h5;
    localparam logic [RSEL_W-1:0] SEL_CUR_HI = 4'h6;
    localparam logic [RSEL_W-1:0] SEL_SA_LO  = 4'h8;
    localparam logic [RSEL_W-1:0] SEL_SA_HI  = 4'h9;
    localparam logic [RSEL_W-1:0] SEL_BC_LO  = 4'hA;
    localparam logic [RSEL_W-1:0] SEL_BC_HI  = 4'hB;

    // command bytes
    localparam logic [BYTE_W-1:0] OP_DUMMY_RD = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_REM_WR   = 8'h12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRESET,
        ST_DUMMY,
        ST_RD_LO,
        ST_RD_HI,
        ST_CAP_HI,
        ST_WAIT,
        ST_SETUP,
        ST_WR_CMD,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [RSEL_W-1:0]   sel;
        logic [BYTE_W-1:0]   data;
    } reg_op_t;

    typedef struct packed {
        logic [CADDR_W-1:0]  count;
        logic [CADDR_W-1:0]  addr;
    } xfer_t;

    localparam reg_op_t OP_NONE = '{wr: 1'b0, rd: 1'b0, sel: '0, data: '0};

    // count+1 and address-1, both wrapping
    function automatic xfer_t shift_xfer(input xfer_t x);
        xfer_t r;
        r.count = x.count + 16'd1;
        r.addr  = x.addr  - 16'd1;
        return r;
    endfunction

    // one entry of the four-write load: count low/high, then address low/high
    function automatic reg_op_t load_op(input logic [IDX_W-1:0] idx, input xfer_t x);
        reg_op_t o;
        o.wr = 1'b1;
        o.rd = 1'b0;
        unique case (idx)
            2'd0:    begin o.sel = SEL_BC_LO; o.data = x.count[7:0];  end
            2'd1:    begin o.sel = SEL_BC_HI; o.data = x.count[15:8]; end
            2'd2:    begin o.sel = SEL_SA_LO; o.data = x.addr[7:0];   end
            default: begin o.sel = SEL_SA_HI; o.data = x.addr[15:8];  end
        endcase
        return o;
    endfunction

    function automatic reg_op_t read_op(input logic [RSEL_W-1:0] s);
        reg_op_t o;
        o.wr   = 1'b0;
        o.rd   = 1'b1;
        o.sel  = s;
        o.data = '0;
        return o;
    endfunction

    function automatic reg_op_t cmd_op(input logic [BYTE_W-1:0] c);
        reg_op_t o;
        o.wr   = 1'b1;
        o.rd   = 1'b0;
        o.sel  = SEL_CMD;
        o.data = c;
        return o;
    endfunction

endpackage

// File: rtl/rdma_ws_delay.sv
module rdma_ws_delay
#(
    parameter int CNT_W = 8
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rdma_ws_tracker.sv
module rdma_ws_tracker
    import rdma_ws_pkg::*;
#(
    parameter int LIM_W = 8
)
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               cap_lo,
    input  logic               cap_hi,
    input  logic [BYTE_W-1:0]  rd_byte,
    input  logic [LIM_W-1:0]   limit,
    output logic               changed,
    output logic               have_prev,
    output logic               limit_hit
);

    localparam int STALL_W = LIM_W + 1;

    logic [BYTE_W-1:0]  lo_q;
    logic [CADDR_W-1:0] prev_q;
    logic               have_q;
    logic [STALL_W-1:0] stall_q;
    logic [STALL_W-1:0] stall_nx;
    logic [CADDR_W-1:0] cur;

    assign cur       = {rd_byte, lo_q};
    assign changed   = have_q && (cur != prev_q);
    assign have_prev = have_q;
    assign stall_nx  = stall_q + 1'b1;
    assign limit_hit = have_q && !changed && (stall_nx >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lo_q    <= '0;
            prev_q  <= '0;
            have_q  <= 1'b0;
            stall_q <= '0;
        end else begin
            if (cap_lo) begin
                lo_q <= rd_byte;
            end
            if (cap_hi) begin
                prev_q <= cur;
                have_q <= 1'b1;
                if (have_q && !changed) begin
                    stall_q <= stall_nx;
                end
            end
        end
    end

endmodule

// File: rtl/rdma_ws_portmux.sv
module rdma_ws_portmux
    import rdma_ws_pkg::*;
(
    input  seq_state_e        state,
    input  logic [IDX_W-1:0]  idx,
    input  xfer_t             xfer,
    output reg_op_t           op
);

    xfer_t   adj;
    reg_op_t pre_tab [SETUP_N];
    reg_op_t set_tab [SETUP_N];

    assign adj = shift_xfer(xfer);

    for (genvar g = 0; g < SETUP_N; g++) begin : g_tab
        assign pre_tab[g] = load_op(IDX_W'(g), adj);
        assign set_tab[g] = load_op(IDX_W'(g), xfer);
    end

    always_comb begin
        op = OP_NONE;
        unique case (state)
            ST_PRESET: op = pre_tab[idx];
            ST_DUMMY:  op = cmd_op(OP_DUMMY_RD);
            ST_RD_LO:  op = read_op(SEL_CUR_LO);
            ST_RD_HI:  op = read_op(SEL_CUR_HI);
            ST_SETUP:  op = set_tab[idx];
            ST_WR_CMD: op = cmd_op(OP_REM_WR);
            default:   op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/rdma_wsetup_seq.sv
module rdma_wsetup_seq
    import rdma_ws_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LIM_W = 8
)
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                pre_adjust,
    input  logic [15:0]         xfer_count,
    input  logic [15:0]         xfer_addr,
    input  logic [DLY_W-1:0]    poll_delay,
    input  logic [LIM_W-1:0]    poll_limit,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [3:0]          reg_addr,
    output logic [7:0]          reg_wdata,
    input  logic [7:0]          reg_rdata,
    output logic                busy,
    output logic                done,
    output logic                timeout_err
);

    seq_state_e        st_q, st_nx;
    logic [IDX_W-1:0]  idx_q;
    xfer_t             xfer_q;
    logic              mode_q;
    logic [DLY_W-1:0]  dly_q;
    logic [LIM_W-1:0]  lim_q;
    logic              err_q;

    logic              accept;
    logic              last_idx;
    logic              changed, have_prev, limit_hit, expired;
    reg_op_t           op;

    assign accept   = (st_q == ST_IDLE) && start;
    assign last_idx = (idx_q == IDX_W'(SETUP_N - 1));

    rdma_ws_tracker #(.LIM_W(LIM_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .cap_lo    (st_q == ST_RD_HI),
        .cap_hi    (st_q == ST_CAP_HI),
        .rd_byte   (reg_rdata),
        .limit     (lim_q),
        .changed   (changed),
        .have_prev (have_prev),
        .limit_hit (limit_hit)
    );

    rdma_ws_delay #(.CNT_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (st_q == ST_CAP_HI),
        .load_val (dly_q),
        .expired  (expired)
    );

    rdma_ws_portmux u_mux (
        .state (st_q),
        .idx   (idx_q),
        .xfer  (xfer_q),
        .op    (op)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_nx = pre_adjust ? ST_PRESET : ST_DUMMY;
            ST_PRESET: if (last_idx) st_nx = ST_DUMMY;
            ST_DUMMY:  st_nx = ST_RD_LO;
            ST_RD_LO:  st_nx = ST_RD_HI;
            ST_RD_HI:  st_nx = ST_CAP_HI;
            ST_CAP_HI: begin
                if (!have_prev)     st_nx = ST_WAIT;
                else if (changed)   st_nx = mode_q ? ST_WR_CMD : ST_SETUP;
                else if (limit_hit) st_nx = ST_FIN;
                else                st_nx = ST_WAIT;
            end
            ST_WAIT:   if (expired) st_nx = ST_RD_LO;
            ST_SETUP:  if (last_idx) st_nx = ST_WR_CMD;
            ST_WR_CMD: st_nx = ST_FIN;
            ST_FIN:    st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            xfer_q <= '0;
            mode_q <= 1'b0;
            dly_q  <= '0;
            lim_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (accept) begin
                xfer_q <= '{count: xfer_count, addr: xfer_addr};
                mode_q <= pre_adjust;
                dly_q  <= poll_delay;
                lim_q  <= poll_limit;
                err_q  <= 1'b0;
            end
            if ((st_q == ST_PRESET) || (st_q == ST_SETUP)) begin
                idx_q <= last_idx ? '0 : idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
            if ((st_q == ST_CAP_HI) && have_prev && !changed && limit_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    assign reg_wr      = op.wr;
    assign reg_rd      = op.rd;
    assign reg_addr    = op.sel;
    assign reg_wdata   = op.data;
    assign busy        = (st_q != ST_IDLE);
    assign done        = (st_q == ST_FIN);
    assign timeout_err = err_q;

endmodule

// File: rtl/rdma_wsetup_chk.sv
module rdma_wsetup_chk
    import rdma_ws_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!reg_rd && !reg_wr));

    p_hi_after_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == SEL_CUR_LO) |=> (reg_rd && reg_addr == SEL_CUR_HI));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_on_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_done_after_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !timeout_err) |-> $past(reg_wr && reg_addr == SEL_CMD && reg_wdata == OP_REM_WR));

    p_timeout_no_wr_r9: assert property (@(posedge clk) disable iff (rst)
        (done && timeout_err) |-> !$past(reg_wr));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (timeout_err && !(start && !busy)) |=> timeout_err);

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

endmodule

bind rdma_wsetup_seq rdma_wsetup_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata)
);

// File: tb/rdma_wsetup_seq_tb_top.sv
`timescale 1ns/1ps
module rdma_wsetup_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pre_adjust = 1'b0;
    logic [15:0] xfer_count = '0;
    logic [15:0] xfer_addr = '0;
    logic [7:0]  poll_delay = '0;
    logic [7:0]  poll_limit = '0;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        busy, done, timeout_err;

    always #5 clk = ~clk;

    rdma_wsetup_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .pre_adjust(pre_adjust),
        .xfer_count(xfer_count), .xfer_addr(xfer_addr),
        .poll_delay(poll_delay), .poll_limit(poll_limit),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .timeout_err(timeout_err)
    );

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // controller model: address register moves once poll index reaches chg_at
    int          hi_reads = 0;
    int          chg_at   = 1;
    logic [15:0] base_val = 16'h3000;
    logic [15:0] delta    = 16'h0101;

    function automatic logic [15:0] cur_val(input int k);
        return (k >= chg_at) ? base_val + delta : base_val;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (reg_addr == 4'h5) reg_rdata <= cur_val(hi_reads)[7:0];
            else if (reg_addr == 4'h6) begin
                reg_rdata <= cur_val(hi_reads)[15:8];
                hi_reads  <= hi_reads + 1;
            end else reg_rdata <= 8'hEE;
        end
    end

    // scoreboard
    typedef struct { bit wr; logic [3:0] a; logic [7:0] d; string req; } txn_t;
    txn_t exp_q[$];
    int   last_cmd_cyc = -1;
    int   prev_hi_cyc  = -1;
    int   exp_gap      = 3;

    task automatic push(input bit wr, input logic [3:0] a, input logic [7:0] d, input string req);
        txn_t t;
        t.wr = wr; t.a = a; t.d = d; t.req = req;
        exp_q.push_back(t);
    endtask

    always @(negedge clk) begin
        if (!rst && (reg_wr || reg_rd)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected strobe addr", int'(reg_addr), 0);
            end else begin
                txn_t t;
                t = exp_q.pop_front();
                check(reg_wr == t.wr && reg_rd == !t.wr, t.req, "strobe kind", int'(reg_wr), int'(t.wr));
                check(reg_addr == t.a, t.req, "register select", int'(reg_addr), int'(t.a));
                if (t.wr) check(reg_wdata == t.d, t.req, "write data", int'(reg_wdata), int'(t.d));
            end
            if (reg_wr && reg_addr == 4'h0 && reg_wdata == 8'h12) last_cmd_cyc = cyc;
            if (reg_rd && reg_addr == 4'h5 && prev_hi_cyc >= 0)
                check(cyc - prev_hi_cyc == exp_gap, "R5", "poll spacing", cyc - prev_hi_cyc, exp_gap);
            if (reg_rd && reg_addr == 4'h6) prev_hi_cyc = cyc;
        end
    end

    task automatic push_loads(input logic [15:0] c, input logic [15:0] a, input string req);
        push(1, 4'hA, c[7:0],  req);
        push(1, 4'hB, c[15:8], req);
        push(1, 4'h8, a[7:0],  req);
        push(1, 4'h9, a[15:8], req);
    endtask

    task automatic run(input bit pre, input logic [15:0] c, input logic [15:0] a,
                       input int d, input int lim, input int chg,
                       input logic [15:0] dl, input int poke);
        bit success;
        int npolls;
        bit seen;
        success  = (chg <= lim);
        npolls   = success ? chg + 1 : lim + 1;
        @(negedge clk);
        hi_reads = 0; chg_at = chg; delta = dl; base_val = a ^ 16'h5A5A;
        exp_gap = d + 3; prev_hi_cyc = -1; last_cmd_cyc = -1;
        if (pre) push_loads(c + 16'd1, a - 16'd1, "R3");
        push(1, 4'h0, 8'h0A, "R2");
        for (int k = 0; k < npolls; k++) begin
            push(0, 4'h5, 8'h00, "R4");
            push(0, 4'h6, 8'h00, "R4");
        end
        if (success) begin
            if (!pre) push_loads(c, a, "R6");
            push(1, 4'h0, 8'h12, pre ? "R7" : "R6");
        end
        pre_adjust = pre; xfer_count = c; xfer_addr = a;
        poll_delay = 8'(d); poll_limit = 8'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        check(timeout_err == 1'b0, "R9", "error cleared by start", int'(timeout_err), 0);
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            if (poke > 0 && i == poke) begin
                start = 1'b1; pre_adjust = !pre; xfer_count = ~c; xfer_addr = ~a;
                poll_delay = 8'd0; poll_limit = 8'd1;
            end else start = 1'b0;
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        start = 1'b0;
        check(seen, "R8", "done seen", int'(seen), 1);
        if (success) check(cyc == last_cmd_cyc + 1, "R8", "done cycle after command", cyc, last_cmd_cyc + 1);
        else check(last_cmd_cyc == -1, "R9", "no write command on timeout", last_cmd_cyc, -1);
        check(busy == 1'b1, "R8", "busy during done", int'(busy), 1);
        check(timeout_err == !success, success ? "R10" : "R9", "error at done",
              int'(timeout_err), int'(!success));
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
        check(busy == 1'b0, "R8", "busy drops", int'(busy), 0);
        check(exp_q.size() == 0, poke > 0 ? "R11" : "R6", "transactions left", exp_q.size(), 0);
        exp_q.delete();
        if (!success) begin
            repeat (3) @(negedge clk);
            check(timeout_err == 1'b1, "R9", "error holds", int'(timeout_err), 1);
            check(!reg_rd && !reg_wr, "R9", "quiet after timeout", int'(reg_rd | reg_wr), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !timeout_err, "R1", "reset outputs", int'({busy, done, timeout_err}), 0);
        check(!reg_rd && !reg_wr, "R1", "idle strobes", int'({reg_rd, reg_wr}), 0);
        run(0, 16'h0040, 16'h1200, 2, 5, 1, 16'h0101, 0);   // R2 R6 basic
        run(0, 16'h05DC, 16'h4000, 0, 6, 3, 16'h0100, 0);   // R4 high byte only
        run(0, 16'h0101, 16'hBEEF, 5, 6, 2, 16'h0001, 0);   // R4 low byte only, R5
        run(1, 16'hFFFF, 16'h0000, 1, 4, 2, 16'h0101, 0);   // R3 wrap, R7
        run(0, 16'h0010, 16'h2000, 1, 3, 100, 16'h0101, 0); // R9 timeout
        run(0, 16'h0020, 16'h2100, 1, 3, 3, 16'h0101, 0);   // R10 change on last poll
        run(1, 16'h0080, 16'h7F00, 1, 3, 4, 16'h0101, 0);   // R9 one poll too late
        run(0, 16'h0300, 16'h0800, 4, 5, 2, 16'h0202, 6);   // R11 start while busy
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #1000000;
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule